// File: doc/BRIEF.md
# Per-Thread Address Monitor Table

This block keeps one address-monitor slot for each hardware thread of a multithreaded core, so that a thread can park itself until a chosen memory line is written. A thread first arms its slot with a virtual address. It then issues a wait carrying the already translated physical address. The slot records the line base of that address and marks the thread as waiting. If a wakeup is already pending for that thread, the block does not record the wait. It consumes the pending wakeup and tells the thread not to sleep.

A write/snoop port presents physical addresses of lines being written. Each armed and waiting slot whose stored line matches the snooped line gets a pending wakeup, leaves the armed and waiting states, and emits a one-cycle wakeup pulse. The block also reports an error for requests that name a thread that does not exist. A side lookup port returns the stored addresses of any slot.

Top module: `thread_monitor_table`

## Requirements
- R1: A synchronous active-high reset clears, for every thread, the armed, waiting and pending flags and the stored virtual and physical addresses. It also clears the response, error and wakeup outputs.
- R2: An arm request (`req_is_wait`=0) for thread t sets t's armed flag, stores `req_addr` as t's virtual address and clears t's physical address to zero. The result is visible on the cycle after the request.
- R3: A wait request (`req_is_wait`=1) for thread t with no pending wakeup stores `req_addr` with its low log2(LINE_BYTES) bits cleared as t's physical address and sets t's waiting flag. On the next cycle it raises `resp_valid` with `resp_sleep`=1 and `resp_tid`=t.
- R4: A wait request for thread t whose pending flag is set clears that flag and leaves waiting and the addresses unchanged. On the next cycle it raises `resp_valid` with `resp_sleep`=0.
- R5: A snoop whose line address (low log2(LINE_BYTES) bits cleared) equals the stored physical address of a thread that is both armed and waiting does three things. It sets that thread's pending flag, clears its armed and waiting flags, and pulses bit t of `wake_pulse` for exactly the following cycle.
- R6: A snoop that matches no armed and waiting slot changes no state and produces no wakeup pulse.
- R7: A request whose `req_tid` is NUM_THREADS or more changes no state and gives no response. It raises `req_error` for one cycle on the next cycle.
- R8: When a snoop match and a wait request for the same thread arrive in the same cycle, the snoop takes effect first. The wait answers `resp_sleep`=0, the pending flag ends cleared, and the wakeup pulse still appears.
- R9: A request or snoop affecting thread t never changes another thread's flags or addresses.
- R10: When a snoop match and an arm request for the same thread arrive in the same cycle, the thread ends armed with the new virtual address and a zero physical address, and its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_is_wait | input | 1 | 0 = arm, 1 = wait |
| req_tid | input | TID_W | Thread of the request, log2(NUM_THREADS)+1 bits |
| req_addr | input | ADDR_W | Virtual address (arm) or physical address (wait) |
| snoop_valid | input | 1 | Snooped write strobe |
| snoop_addr | input | ADDR_W | Physical address of snooped write |
| resp_valid | output | 1 | Wait response strobe, one cycle after the wait |
| resp_sleep | output | 1 | 1 = sleep, 0 = do not sleep |
| resp_tid | output | TID_W | Thread the response belongs to |
| req_error | output | 1 | Illegal thread ID seen on the previous cycle |
| wake_pulse | output | NUM_THREADS | Per-thread one-cycle wakeup |
| armed_o | output | NUM_THREADS | Per-thread armed flags |
| waiting_o | output | NUM_THREADS | Per-thread waiting flags |
| pending_o | output | NUM_THREADS | Per-thread pending wakeup flags |
| peek_tid | input | IDX_W | Slot selected for address lookup |
| peek_vaddr | output | ADDR_W | Stored virtual address of selected slot |
| peek_paddr | output | ADDR_W | Stored physical address of selected slot |

## Verification
The assertions watch, on every cycle, that a response only follows a legal wait, that an error never coincides with a response, and that a sleep answer leaves the thread waiting. They also check that a no-sleep answer leaves nothing pending and that a wakeup pulse leaves its thread not waiting. The stored addresses, the line alignment, the ordering of a snoop against an arm or wait in the same cycle, and the isolation between threads can only be shown by the bench. It does so through directed scenarios and a long random run compared against a reference model of the slots.

// File: rtl/thread_monitor_table.sv
module thread_monitor_table #(
  parameter int NUM_THREADS = 2,
  parameter int LINE_BYTES  = 64,
  parameter int ADDR_W      = 48,
  localparam int TID_W = $clog2(NUM_THREADS) + 1,
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_is_wait,
  input  logic [TID_W-1:0]       req_tid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   snoop_valid,
  input  logic [ADDR_W-1:0]      snoop_addr,
  output logic                   resp_valid,
  output logic                   resp_sleep,
  output logic [TID_W-1:0]       resp_tid,
  output logic                   req_error,
  output logic [NUM_THREADS-1:0] wake_pulse,
  output logic [NUM_THREADS-1:0] armed_o,
  output logic [NUM_THREADS-1:0] waiting_o,
  output logic [NUM_THREADS-1:0] pending_o,
  input  logic [IDX_W-1:0]       peek_tid,
  output logic [ADDR_W-1:0]      peek_vaddr,
  output logic [ADDR_W-1:0]      peek_paddr
);

  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic                   tid_ok;
  logic                   sleep_now;
  logic [ADDR_W-1:0]      snoop_line;
  logic [ADDR_W-1:0]      req_line;
  logic [NUM_THREADS-1:0] hit;
  logic [NUM_THREADS-1:0] sel;
  logic [NUM_THREADS-1:0] pend_eff;
  logic [ADDR_W-1:0]      vaddr_arr [NUM_THREADS];
  logic [ADDR_W-1:0]      paddr_arr [NUM_THREADS];

  assign tid_ok     = req_tid < TID_W'(NUM_THREADS);
  assign snoop_line = snoop_addr & LINE_MASK;
  assign req_line   = req_addr & LINE_MASK;
  assign sleep_now  = |(sel & ~pend_eff);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic              armed_r, wait_r, pend_r;
    logic              armed_n, wait_n, pend_n;
    logic [ADDR_W-1:0] va_r, pa_r, va_n, pa_n;

    assign hit[t]      = snoop_valid && armed_r && wait_r && (pa_r == snoop_line);
    assign sel[t]      = req_valid && tid_ok && (req_tid == TID_W'(t));
    assign pend_eff[t] = pend_r | hit[t];

    always_comb begin
      armed_n = armed_r & ~hit[t];
      wait_n  = wait_r & ~hit[t];
      pend_n  = pend_eff[t];
      va_n    = va_r;
      pa_n    = pa_r;
      if (sel[t] && !req_is_wait) begin
        armed_n = 1'b1;
        va_n    = req_addr;
        pa_n    = '0;
      end else if (sel[t] && req_is_wait) begin
        if (pend_eff[t]) begin
          pend_n = 1'b0;
        end else begin
          pa_n   = req_line;
          wait_n = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        armed_r <= 1'b0;
        wait_r  <= 1'b0;
        pend_r  <= 1'b0;
        va_r    <= '0;
        pa_r    <= '0;
      end else begin
        armed_r <= armed_n;
        wait_r  <= wait_n;
        pend_r  <= pend_n;
        va_r    <= va_n;
        pa_r    <= pa_n;
      end
    end

    assign armed_o[t]   = armed_r;
    assign waiting_o[t] = wait_r;
    assign pending_o[t] = pend_r;
    assign vaddr_arr[t] = va_r;
    assign paddr_arr[t] = pa_r;

    // R5: a woken thread is no longer waiting
    p_wake_not_waiting_r5: assert property (@(posedge clk) disable iff (rst)
      wake_pulse[t] |-> !wait_r);

    // R3: a sleep answer leaves the thread waiting
    p_sleep_waiting_r3: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_sleep && resp_tid == TID_W'(t)) |-> wait_r);

    // R4: a no-sleep answer consumed the pending wakeup
    p_nosleep_consumed_r4: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && !resp_sleep && resp_tid == TID_W'(t)) |-> !pend_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_sleep <= 1'b0;
      resp_tid   <= '0;
      req_error  <= 1'b0;
      wake_pulse <= '0;
    end else begin
      resp_valid <= req_valid && req_is_wait && tid_ok;
      resp_sleep <= sleep_now;
      resp_tid   <= req_tid;
      req_error  <= req_valid && !tid_ok;
      wake_pulse <= hit;
    end
  end

  assign peek_vaddr = (32'(peek_tid) < NUM_THREADS) ? vaddr_arr[peek_tid] : '0;
  assign peek_paddr = (32'(peek_tid) < NUM_THREADS) ? paddr_arr[peek_tid] : '0;

  p_resp_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid && req_is_wait && tid_ok));

  p_error_no_resp_r7: assert property (@(posedge clk) disable iff (rst)
    req_error |-> (!resp_valid && $past(req_valid && !tid_ok)));

endmodule

// File: tb/thread_monitor_table_tb_top.sv
`timescale 1ns/1ps
module thread_monitor_table_tb_top;
  localparam int N  = 2;
  localparam int LB = 64;
  localparam int AW = 48;
  localparam int TW = $clog2(N) + 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] MASK = ~AW'(LB - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_is_wait = 1'b0;
  logic [TW-1:0] req_tid = '0;
  logic [AW-1:0] req_addr = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          resp_valid, resp_sleep, req_error;
  logic [TW-1:0] resp_tid;
  logic [N-1:0]  wake_pulse, armed_o, waiting_o, pending_o;
  logic [IW-1:0] peek_tid = '0;
  logic [AW-1:0] peek_vaddr, peek_paddr;

  always #2.5 clk = ~clk;

  thread_monitor_table #(.NUM_THREADS(N), .LINE_BYTES(LB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_wait(req_is_wait),
    .req_tid(req_tid), .req_addr(req_addr), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .resp_valid(resp_valid), .resp_sleep(resp_sleep),
    .resp_tid(resp_tid), .req_error(req_error), .wake_pulse(wake_pulse),
    .armed_o(armed_o), .waiting_o(waiting_o), .pending_o(pending_o),
    .peek_tid(peek_tid), .peek_vaddr(peek_vaddr), .peek_paddr(peek_paddr)
  );

  bit            m_arm [N];
  bit            m_wait[N];
  bit            m_pend[N];
  logic [AW-1:0] m_va  [N];
  logic [AW-1:0] m_pa  [N];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pack(input bit v[N]);
    logic [N-1:0] r;
    for (int t = 0; t < N; t++) r[t] = v[t];
    return r;
  endfunction

  task automatic check_state(input string req);
    chk(req, "armed", 64'(armed_o), 64'(pack(m_arm)));
    chk(req, "waiting", 64'(waiting_o), 64'(pack(m_wait)));
    chk(req, "pending", 64'(pending_o), 64'(pack(m_pend)));
    for (int t = 0; t < N; t++) begin
      peek_tid = IW'(t);
      #0.5;
      chk(req, "peek_vaddr", 64'(peek_vaddr), 64'(m_va[t]));
      chk(req, "peek_paddr", 64'(peek_paddr), 64'(m_pa[t]));
    end
  endtask

  task automatic cyc(input bit rv, input bit iw, input logic [TW-1:0] tid, input logic [AW-1:0] addr,
                     input bit sv, input logic [AW-1:0] saddr, input string req);
    bit           e_rv, e_err, e_sleep;
    logic [N-1:0] e_wake;
    req_valid = rv; req_is_wait = iw; req_tid = tid; req_addr = addr;
    snoop_valid = sv; snoop_addr = saddr;
    e_rv = rv && iw && (32'(tid) < N);
    e_err = rv && (32'(tid) >= N);
    e_sleep = 1'b0;
    e_wake = '0;
    for (int t = 0; t < N; t++) begin
      if (sv && m_arm[t] && m_wait[t] && m_pa[t] == (saddr & MASK)) begin
        m_pend[t] = 1'b1; m_wait[t] = 1'b0; m_arm[t] = 1'b0; e_wake[t] = 1'b1;
      end
    end
    if (rv && 32'(tid) < N) begin
      int t = 32'(tid);
      if (!iw) begin
        m_arm[t] = 1'b1; m_va[t] = addr; m_pa[t] = '0;
      end else if (m_pend[t]) begin
        m_pend[t] = 1'b0;
      end else begin
        m_pa[t] = addr & MASK; m_wait[t] = 1'b1; e_sleep = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = 1'b0;
    chk(req, "resp_valid", 64'(resp_valid), 64'(e_rv));
    if (e_rv) begin
      chk(req, "resp_sleep", 64'(resp_sleep), 64'(e_sleep));
      chk(req, "resp_tid", 64'(resp_tid), 64'(tid));
    end
    chk(req, "req_error", 64'(req_error), 64'(e_err));
    chk(req, "wake_pulse", 64'(wake_pulse), 64'(e_wake));
    check_state(req);
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    return AW'({$urandom(), $urandom()});
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    for (int t = 0; t < N; t++) begin
      m_arm[t] = 0; m_wait[t] = 0; m_pend[t] = 0; m_va[t] = '0; m_pa[t] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "resp_valid", 64'(resp_valid), 64'(0));
    chk("R1", "req_error", 64'(req_error), 64'(0));
    chk("R1", "wake_pulse", 64'(wake_pulse), 64'(0));
    check_state("R1");

    // R2: arm thread 0
    cyc(1, 0, 2'd0, 48'h0000_1111_2222, 0, '0, "R2");
    // R3: wait with unaligned address, line base recorded
    a = 48'h1234_5678_9ABF;
    cyc(1, 1, 2'd0, a, 0, '0, "R3");
    chk("R3", "aligned paddr", 64'(m_pa[0]), 64'(48'h1234_5678_9A80));
    // R6: snoop to a neighbouring line, no effect
    cyc(0, 0, 2'd0, '0, 1, 48'h1234_5678_9AC0, "R6");
    // R5: snoop to the same line at another byte
    cyc(0, 0, 2'd0, '0, 1, 48'h1234_5678_9A83, "R5");
    // R4: wait with pending wakeup does not sleep
    cyc(1, 1, 2'd0, 48'h0000_0000_4000, 0, '0, "R4");
    // R7: illegal thread IDs ignored
    cyc(1, 0, 2'd2, 48'hFFFF_FFFF_FFFF, 0, '0, "R7");
    cyc(1, 1, 2'd3, 48'hFFFF_FFFF_FFFF, 0, '0, "R7");
    // R8: snoop and wait on the same thread in one cycle
    cyc(1, 0, 2'd1, 48'h0000_AAAA_0000, 0, '0, "R8");
    cyc(1, 1, 2'd1, 48'h0000_BBBB_0040, 0, '0, "R8");
    cyc(1, 1, 2'd1, 48'h0000_0000_0000, 1, 48'h0000_BBBB_0055, "R8");
    // R10: snoop and arm on the same thread in one cycle
    cyc(1, 0, 2'd0, 48'h0000_0000_7000, 0, '0, "R10");
    cyc(1, 1, 2'd0, 48'h0000_CCCC_0100, 0, '0, "R10");
    cyc(1, 0, 2'd0, 48'h0000_DDDD_0000, 1, 48'h0000_CCCC_013F, "R10");
    // R9: thread 1 activity leaves thread 0 untouched
    cyc(1, 0, 2'd1, 48'h0000_5555_0000, 0, '0, "R9");
    cyc(1, 1, 2'd1, 48'h0000_6666_0000, 0, '0, "R9");

    // R9: random mix of arms, waits, snoops and illegal IDs
    for (int i = 0; i < 3000; i++) begin
      bit            rv, iw, sv;
      logic [TW-1:0] tid;
      logic [AW-1:0] sa;
      rv  = ($urandom() % 3) != 0;
      iw  = ($urandom() % 2) != 0;
      tid = (($urandom() % 8) == 0) ? TW'(2 + $urandom() % 2) : TW'($urandom() % N);
      sv  = ($urandom() % 3) == 0;
      if (($urandom() % 4) != 0) sa = m_pa[$urandom() % N] | AW'($urandom() % LB);
      else sa = rnd_addr();
      if (($urandom() % 4) == 0) a = m_pa[$urandom() % N] | AW'($urandom() % LB);
      else a = rnd_addr();
      cyc(rv, iw, tid, a, sv, sa, "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule